// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Request

This block holds the status flags of an I2C master/slave controller and merges them into one interrupt request for the system interrupt controller. The serial shifter sends it single-cycle event strobes: the first bit of a byte has gone onto the wire, a byte has come in, the final data bit of a received byte is in progress, and a stop condition was seen. Register access strobes come from the bus interface. These are a data-register write, a data-register read and a status-register read. Control bits set the mode and the flag policy.

Three flags are kept: transmit-empty, receive-full and slave-address-match. Two indicator bits show whether an address match was a general call or a start byte. A clock-stretch request asks the bus driver to hold SCL low, so a received byte never overruns an unread one. While the controller is disabled, the flags are held clear and the interrupt line follows the baud-rate tick. In that state the block works as a general-purpose timer interrupt.

Top module: `i2c_irq_status`

## Requirements
- R1: `tx_empty` goes to 1 one cycle after `ev_tx_first` only if `en`, `txi` and `hold_empty` are all 1 and `tx_kind` allows it. `tx_kind` 0 (data byte) and 1 (first byte of a 10-bit address) always allow it. `tx_kind` 2 (final address byte) allows it only when `rd_bit` is 0. `tx_kind` 3 never allows it.
- R2: A `dr_wr` or a `stat_rd` pulse clears `tx_empty` on the next cycle.
- R3: In master mode (`slave_mode`=0), a received byte with `rx_is_addr`=0 sets `rx_full` on the next cycle. A `dr_rd` or a `stat_rd` pulse clears it.
- R4: In slave mode with `irm`=0, an address byte does not set `rx_full`. A data byte sets it only after the most recent address byte matched and no `ev_stop` has come since. With `irm`=1, every received byte in slave mode sets `rx_full`.
- R5: In slave mode, an address byte sets `sam` when `rx_byte[7:1]` equals `own_addr`, when the byte is 0x00, or when the byte is 0x01. `gcall` is 1 for 0x00 and `sbyte` is 1 for 0x01. All three clear on `stat_rd`.
- R6: `ev_rx_last` while `rx_full` is 1 raises `scl_hold` on the next cycle. `scl_hold` stays 1 until `rx_full` clears, and drops in the same cycle that `rx_full` drops. `ev_rx_last` has no effect while `rx_full` is 0.
- R7: While `en`=1, `irq` is the OR of `tx_empty`, `rx_full` and `sam`, and `brg_tick` has no effect on it.
- R8: While `en`=0, `irq` equals `brg_tick`. One cycle after `en` falls, all flags, the indicators and `scl_hold` are 0.
- R9: If a set event and a clearing access for the same flag arrive in the same cycle, the flag ends up 1.
- R10: A synchronous reset (`rst`=1) clears every flag, indicator and `scl_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Controller enable |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| txi | input | 1 | Transmit-empty interrupt enable |
| rd_bit | input | 1 | Read direction of the current transfer |
| irm | input | 1 | Interactive receive: flag every slave byte |
| own_addr | input | ADDR_W | Programmed slave address |
| hold_empty | input | 1 | Transmit holding register is empty |
| ev_tx_first | input | 1 | First bit of a byte shifted out |
| tx_kind | input | 2 | Kind of byte being shifted out |
| ev_rx_byte | input | 1 | A complete byte has been received |
| rx_is_addr | input | 1 | The received byte is an address byte |
| rx_byte | input | ADDR_W+1 | Received byte value |
| ev_rx_last | input | 1 | Final data bit of a received byte in progress |
| ev_stop | input | 1 | Stop condition seen |
| dr_wr | input | 1 | Data register write |
| dr_rd | input | 1 | Data register read |
| stat_rd | input | 1 | Status register read |
| brg_tick | input | 1 | Baud-rate generator tick |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| sam | output | 1 | Slave address match flag |
| gcall | output | 1 | Match was a general call |
| sbyte | output | 1 | Match was a start byte |
| irq | output | 1 | Combined interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench walks every combination of transmit byte kind and read direction. A design that raised transmit-empty on the final address byte of a read would ask software for data that is never sent. In slave mode it replays matching and non-matching addresses, a general call, a start byte, a stop after a match, and interactive mode. A wrong addressed state would either report bytes meant for another slave or lose bytes meant for this one. It also checks clock stretching across a late data read. A design that released SCL early would overrun the unread byte, and one that kept it low would hang the bus. Same-cycle set-and-clear cases are included, because a clear that wins would silently drop an event.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef enum logic [1:0] {
    TXK_DATA      = 2'd0,
    TXK_ADDR10_HI = 2'd1,
    TXK_ADDR_LAST = 2'd2,
    TXK_NONE      = 2'd3
  } txk_e;

  // Shift points at which the transmit-empty flag may be raised
  function automatic logic tx_point_ok(input logic [1:0] kind, input logic rd);
    case (kind)
      TXK_DATA:      return 1'b1;
      TXK_ADDR10_HI: return 1'b1;
      TXK_ADDR_LAST: return !rd;
      default:       return 1'b0;
    endcase
  endfunction

  // Next value of a flag; the set event wins over a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/i2c_tx_flag.sv
module i2c_tx_flag
  import i2c_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       txi,
  input  logic       rd_bit,
  input  logic       hold_empty,
  input  logic       ev_tx_first,
  input  logic [1:0] tx_kind,
  input  logic       dr_wr,
  input  logic       stat_rd,
  output logic       tx_empty
);

  logic tx_set, tx_clr;

  assign tx_set = en & txi & hold_empty & ev_tx_first & tx_point_ok(tx_kind, rd_bit);
  assign tx_clr = dr_wr | stat_rd;

  always_ff @(posedge clk) begin
    if (rst || !en) tx_empty <= 1'b0;
    else            tx_empty <= flag_next(tx_empty, tx_set, tx_clr);
  end

  p_no_set_without_txi_r1: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !(ev_tx_first && txi)) |=> !tx_empty);

  p_wr_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (dr_wr && !tx_set) |=> !tx_empty);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_set && tx_clr) |=> tx_empty);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              slave_mode,
  input  logic              ev_rx_byte,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ev_stop,
  input  logic              stat_rd,
  output logic              sam,
  output logic              gcall,
  output logic              sbyte,
  output logic              addressed
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam logic [BYTE_W-1:0] GCALL_CODE = '0;
  localparam logic [BYTE_W-1:0] SBYTE_CODE = BYTE_W'(1);

  function automatic logic own_hit(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] a);
    return b[BYTE_W-1:1] == a;
  endfunction

  logic addr_ev, gc_hit, sb_hit, any_hit, sam_set;

  assign addr_ev = en & slave_mode & ev_rx_byte & rx_is_addr;
  assign gc_hit  = (rx_byte == GCALL_CODE);
  assign sb_hit  = (rx_byte == SBYTE_CODE);
  assign any_hit = own_hit(rx_byte, own_addr) | gc_hit | sb_hit;
  assign sam_set = addr_ev & any_hit;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sam   <= 1'b0;
      gcall <= 1'b0;
      sbyte <= 1'b0;
    end else if (sam_set) begin
      sam   <= 1'b1;
      gcall <= gc_hit;
      sbyte <= sb_hit;
    end else if (stat_rd) begin
      sam   <= 1'b0;
      gcall <= 1'b0;
      sbyte <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !slave_mode) addressed <= 1'b0;
    else if (addr_ev)              addressed <= any_hit;
    else if (ev_stop)              addressed <= 1'b0;
  end

  p_ind_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gcall, sbyte}));

  p_ind_needs_sam_r5: assert property (@(posedge clk) disable iff (rst)
    (gcall || sbyte) |-> sam);

  p_stat_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !sam_set) |=> !sam);

endmodule

// File: rtl/i2c_rx_flag.sv
module i2c_rx_flag
  import i2c_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic slave_mode,
  input  logic irm,
  input  logic addressed,
  input  logic ev_rx_byte,
  input  logic rx_is_addr,
  input  logic ev_rx_last,
  input  logic dr_rd,
  input  logic stat_rd,
  output logic rx_full,
  output logic scl_hold
);

  logic rx_take, rx_set, rx_clr, rx_full_d, hold_req;

  // Which received bytes are reported to software
  assign rx_take   = slave_mode ? (irm | (~rx_is_addr & addressed)) : ~rx_is_addr;
  assign rx_set    = en & ev_rx_byte & rx_take;
  assign rx_clr    = dr_rd | stat_rd;
  assign rx_full_d = en & flag_next(rx_full, rx_set, rx_clr);
  assign hold_req  = ev_rx_last & rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full  <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      rx_full  <= rx_full_d;
      scl_hold <= rx_full_d & (scl_hold | hold_req);
    end
  end

  p_hold_needs_full_r6: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> rx_full);

  p_hold_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> $past(ev_rx_last && rx_full));

  p_rd_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (dr_rd && !rx_set) |=> (!rx_full && !scl_hold));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_set && rx_clr) |=> rx_full);

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              slave_mode,
  input  logic              txi,
  input  logic              rd_bit,
  input  logic              irm,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              hold_empty,
  input  logic              ev_tx_first,
  input  logic [1:0]        tx_kind,
  input  logic              ev_rx_byte,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              ev_rx_last,
  input  logic              ev_stop,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              stat_rd,
  input  logic              brg_tick,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              sam,
  output logic              gcall,
  output logic              sbyte,
  output logic              irq,
  output logic              scl_hold
);

  logic addressed;
  logic any_flag;

  i2c_tx_flag u_tx (
    .clk(clk), .rst(rst), .en(en), .txi(txi), .rd_bit(rd_bit),
    .hold_empty(hold_empty), .ev_tx_first(ev_tx_first), .tx_kind(tx_kind),
    .dr_wr(dr_wr), .stat_rd(stat_rd), .tx_empty(tx_empty)
  );

  i2c_addr_match #(.ADDR_W(ADDR_W)) u_am (
    .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode),
    .ev_rx_byte(ev_rx_byte), .rx_is_addr(rx_is_addr), .rx_byte(rx_byte),
    .own_addr(own_addr), .ev_stop(ev_stop), .stat_rd(stat_rd),
    .sam(sam), .gcall(gcall), .sbyte(sbyte), .addressed(addressed)
  );

  i2c_rx_flag u_rx (
    .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode), .irm(irm),
    .addressed(addressed), .ev_rx_byte(ev_rx_byte), .rx_is_addr(rx_is_addr),
    .ev_rx_last(ev_rx_last), .dr_rd(dr_rd), .stat_rd(stat_rd),
    .rx_full(rx_full), .scl_hold(scl_hold)
  );

  assign any_flag = tx_empty | rx_full | sam;
  assign irq      = en ? any_flag : brg_tick;

  p_dis_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(tx_empty || rx_full || sam || scl_hold));

  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (en && irq) |-> (tx_empty || rx_full || sam));

endmodule

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, slave_mode = 1'b0, txi = 1'b0, rd_bit = 1'b0, irm = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic hold_empty = 1'b0, ev_tx_first = 1'b0;
  logic [1:0] tx_kind = 2'd0;
  logic ev_rx_byte = 1'b0, rx_is_addr = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic ev_rx_last = 1'b0, ev_stop = 1'b0, dr_wr = 1'b0, dr_rd = 1'b0, stat_rd = 1'b0;
  logic brg_tick = 1'b0;
  logic tx_empty, rx_full, sam, gcall, sbyte, irq, scl_hold;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode), .txi(txi),
    .rd_bit(rd_bit), .irm(irm), .own_addr(own_addr), .hold_empty(hold_empty),
    .ev_tx_first(ev_tx_first), .tx_kind(tx_kind), .ev_rx_byte(ev_rx_byte),
    .rx_is_addr(rx_is_addr), .rx_byte(rx_byte), .ev_rx_last(ev_rx_last),
    .ev_stop(ev_stop), .dr_wr(dr_wr), .dr_rd(dr_rd), .stat_rd(stat_rd),
    .brg_tick(brg_tick), .tx_empty(tx_empty), .rx_full(rx_full), .sam(sam),
    .gcall(gcall), .sbyte(sbyte), .irq(irq), .scl_hold(scl_hold)
  );

  // {txi, hold_empty, rd_bit, tx_kind[1:0], expected tx_empty}
  localparam int NV = 10;
  localparam logic [5:0] TXV [NV] = '{
    6'b1_1_0_00_1, 6'b1_1_1_00_1, 6'b1_1_0_01_1, 6'b1_1_1_01_1,
    6'b1_1_0_10_1, 6'b1_1_1_10_0, 6'b1_1_0_11_0, 6'b1_1_1_11_0,
    6'b0_1_0_00_0, 6'b1_0_0_00_0
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic rx_ev(input logic is_addr, input logic [7:0] b);
    rx_is_addr = is_addr; rx_byte = b; ev_rx_byte = 1'b1;
    tick();
    ev_rx_byte = 1'b0; rx_is_addr = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    // R10 reset state
    chk(tx_empty, 1'b0, "R10 tx_empty after reset");
    chk(rx_full | sam | gcall | sbyte | scl_hold, 1'b0, "R10 other flags after reset");
    rst = 1'b0; en = 1'b1; tick();
    chk(irq, 1'b0, "R10 irq after reset");

    // R1 vector table
    for (int i = 0; i < NV; i++) begin
      {txi, hold_empty, rd_bit, tx_kind} = TXV[i][5:1];
      ev_tx_first = 1'b1; tick(); ev_tx_first = 1'b0;
      chk(tx_empty, TXV[i][0], $sformatf("R1 vector %0d", i));
      dr_wr = 1'b1; tick(); dr_wr = 1'b0;
      chk(tx_empty, 1'b0, $sformatf("R2 data write clears, vector %0d", i));
    end
    txi = 1'b1; hold_empty = 1'b1; tx_kind = 2'd0; rd_bit = 1'b0;
    ev_tx_first = 1'b1; tick(); ev_tx_first = 1'b0;
    chk(irq, 1'b1, "R7 irq from tx_empty");
    pulse_stat();
    chk(tx_empty, 1'b0, "R2 status read clears tx_empty");
    ev_tx_first = 1'b1; dr_wr = 1'b1; tick(); ev_tx_first = 1'b0; dr_wr = 1'b0;
    chk(tx_empty, 1'b1, "R9 tx set wins over write");
    dr_wr = 1'b1; tick(); dr_wr = 1'b0;
    txi = 1'b0;

    // R3 master receive, R6 stretching
    rx_ev(1'b0, 8'hA5);
    chk(rx_full, 1'b1, "R3 master data byte sets rx_full");
    ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
    chk(scl_hold, 1'b1, "R6 hold raised on last bit with rx_full");
    tick();
    chk(scl_hold, 1'b1, "R6 hold kept while rx_full");
    dr_rd = 1'b1; tick(); dr_rd = 1'b0;
    chk(rx_full, 1'b0, "R3 data read clears rx_full");
    chk(scl_hold, 1'b0, "R6 hold released with rx_full");
    ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
    chk(scl_hold, 1'b0, "R6 last bit with rx_full clear has no effect");
    rx_ev(1'b1, 8'h54);
    chk(rx_full, 1'b0, "R3 master address byte not reported");
    rx_is_addr = 1'b0; rx_byte = 8'h11; ev_rx_byte = 1'b1; dr_rd = 1'b1;
    tick(); ev_rx_byte = 1'b0; dr_rd = 1'b0;
    chk(rx_full, 1'b1, "R9 rx set wins over read");
    pulse_stat();
    chk(rx_full, 1'b0, "R3 status read clears rx_full");
    brg_tick = 1'b1; #1;
    chk(irq, 1'b0, "R7 brg_tick ignored while enabled");
    brg_tick = 1'b0;

    // R4/R5 slave mode
    slave_mode = 1'b1; irm = 1'b0;
    rx_ev(1'b1, 8'h54);
    chk(sam, 1'b1, "R5 own address match");
    chk(gcall | sbyte, 1'b0, "R5 no indicator on own address");
    chk(rx_full, 1'b0, "R4 address byte not reported without irm");
    chk(irq, 1'b1, "R7 irq from sam");
    rx_ev(1'b0, 8'h77);
    chk(rx_full, 1'b1, "R4 data after match reported");
    pulse_stat();
    chk(sam, 1'b0, "R5 status read clears sam");
    rx_ev(1'b1, 8'h30);
    chk(sam, 1'b0, "R5 mismatch does not set sam");
    rx_ev(1'b0, 8'h12);
    chk(rx_full, 1'b0, "R4 data after mismatch not reported");
    rx_ev(1'b1, 8'h00);
    chk(sam & gcall & ~sbyte, 1'b1, "R5 general call");
    pulse_stat();
    chk(gcall, 1'b0, "R5 gcall clears with sam");
    rx_ev(1'b1, 8'h01);
    chk(sam & sbyte & ~gcall, 1'b1, "R5 start byte");
    pulse_stat();
    rx_ev(1'b1, 8'h55);
    pulse_stat();
    ev_stop = 1'b1; tick(); ev_stop = 1'b0;
    rx_ev(1'b0, 8'h66);
    chk(rx_full, 1'b0, "R4 data after stop not reported");
    irm = 1'b1;
    rx_ev(1'b1, 8'h30);
    chk(rx_full, 1'b1, "R4 irm reports mismatched address byte");
    chk(sam, 1'b0, "R5 irm does not force sam");

    // R8 disable
    en = 1'b0; tick();
    chk(rx_full | tx_empty | sam | scl_hold, 1'b0, "R8 flags cleared when disabled");
    brg_tick = 1'b1; #1;
    chk(irq, 1'b1, "R8 irq follows brg_tick high");
    brg_tick = 1'b0; #1;
    chk(irq, 1'b0, "R8 irq follows brg_tick low");
    rx_ev(1'b0, 8'h22);
    chk(rx_full, 1'b0, "R8 byte ignored while disabled");

    finish_run();
  end

endmodule